// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter with Selectable Parity

The block turns parallel bytes into asynchronous serial frames on one output line. A producer hands it a byte together with a 3-bit parity selection over a valid/ready handshake. The byte goes into a one-entry holding register. When the shifter is free, the byte moves into it, and the holding register can then take the next byte while the current frame is still on the line.

Each frame has the following parts. The line idles high. A low start bit opens the frame. The data bits follow, least significant first. A parity bit comes next, unless the selected mode leaves it out. A high stop bit closes the frame. Every bit on the line lasts exactly one period of an external baud-rate strobe.

Each time the shifter takes a byte from the holding register, a one-cycle pulse is raised. Firmware or a DMA engine can use this pulse as a buffer-empty interrupt.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `empty_irq` is 0. The line stays at 1 whenever no frame is being sent.
- R2: A frame opens with a 0 on `txd`, placed on the first `baud_tick` after the byte reaches the shifter. Every bit of the frame then holds for exactly one tick period.
- R3: After the start bit, the DATA_W data bits are sent least significant bit first. Example: byte 0x41 in odd mode gives 0, 1,0,0,0,0,0,1,0, then 1, then 1.
- R4: Mode code 1 (odd) adds a parity bit chosen so that the count of ones in data plus parity is odd.
- R5: Mode code 2 (even) adds a parity bit chosen so that the count of ones in data plus parity is even.
- R6: Mode code 3 (space) adds a parity bit that is always 0. Mode code 4 (mark) adds a parity bit that is always 1.
- R7: Mode code 0 sends no parity bit, and so do the unused codes 5, 6 and 7. The stop bit then comes directly after the last data bit, giving a 10-bit frame.
- R8: Every frame closes with one stop bit at 1, after which the line returns to idle 1.
- R9: `empty_irq` is high for exactly one cycle, in the cycle right after the holding register gives its byte to the shifter. `in_ready` is 1 in that same cycle.
- R10: `in_ready` is 0 while the holding register is full. A byte accepted while a frame is in progress waits in the holding register. Its start bit begins exactly one idle bit period after the previous stop bit ends, so start-to-start spacing is (frame bits + 1) tick periods.
- R11: The parity mode is captured together with the byte at acceptance. Changing `in_mode` afterwards has no effect on that byte's frame, whether the byte is on the line or still waiting in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle strobe, one per bit period |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Holding register is free |
| in_data | input | DATA_W | Byte to send |
| in_mode | input | 3 | Parity selection: 0 none, 1 odd, 2 even, 3 space, 4 mark, 5 to 7 none |
| txd | output | 1 | Serial line, idle high |
| empty_irq | output | 1 | One-cycle pulse when the holding register hands over its byte |

## Verification
The assertions assume that `rst` is high from the first clock edge and that `baud_tick` is a strobe sampled on single cycles. They place no constraint on its spacing, and they make no assumption about when `in_valid` or `in_mode` change. The stimulus generates the tick from a free-running divide-by-8 counter. It raises `in_valid` only at a falling clock edge where `in_ready` is already high, and drops it one cycle later, so every offer is accepted on a known edge. Mode changes are applied only after acceptance, which gives the latching checks a defined frame to compare against.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int TX_DATA_W = 8;
    localparam int MODE_W    = 3;

    localparam logic [MODE_W-1:0] PM_NONE  = 3'd0;
    localparam logic [MODE_W-1:0] PM_ODD   = 3'd1;
    localparam logic [MODE_W-1:0] PM_EVEN  = 3'd2;
    localparam logic [MODE_W-1:0] PM_SPACE = 3'd3;
    localparam logic [MODE_W-1:0] PM_MARK  = 3'd4;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SEND  = 2'd2
    } shift_state_e;

    // True when the mode inserts a parity slot into the frame.
    function automatic logic mode_has_parity(input logic [MODE_W-1:0] m);
        return (m == PM_ODD) || (m == PM_EVEN) || (m == PM_SPACE) || (m == PM_MARK);
    endfunction

    // ones_odd: xor-reduction of the data bits.
    function automatic logic mode_parity_bit(input logic [MODE_W-1:0] m,
                                             input logic ones_odd);
        logic b;
        case (m)
            PM_ODD:  b = ~ones_odd;
            PM_EVEN: b = ones_odd;
            PM_MARK: b = 1'b1;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = TX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MODE_W-1:0] in_mode,
    input  logic              take,
    output logic              in_ready,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic [MODE_W-1:0] hold_mode
);

    logic accept;

    assign in_ready = ~hold_full;
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
            hold_mode <= PM_NONE;
        end else begin
            if (accept) begin
                hold_full <= 1'b1;
                hold_data <= in_data;
                hold_mode <= in_mode;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end

    // R10: an accepted byte occupies the holding register on the next cycle
    p_accept_fills_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (hold_full && !in_ready));

    // R9: the shifter never takes from an empty holding register
    p_take_full_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> hold_full);

    // R11: held byte and mode stay put until handed over
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take) |=> ($stable(hold_data) && $stable(hold_mode)));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = TX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [MODE_W-1:0] load_mode,
    output logic              idle,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    shift_state_e       state_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_d;
    logic [CNT_W-1:0]   left_q;
    logic [CNT_W-1:0]   left_d;
    logic               txd_q;
    logic               with_par;
    logic               par_bit;

    always_comb begin
        with_par = mode_has_parity(load_mode);
        par_bit  = mode_parity_bit(load_mode, ^load_data);
        if (with_par) begin
            frame_d = {1'b1, par_bit, load_data, 1'b0};
            left_d  = CNT_W'(FRAME_W - 1);
        end else begin
            frame_d = {2'b11, load_data, 1'b0};
            left_d  = CNT_W'(FRAME_W - 2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            frame_q <= '1;
            left_q  <= '0;
            txd_q   <= 1'b1;
        end else begin
            case (state_q)
                SH_IDLE: begin
                    if (load) begin
                        frame_q <= frame_d;
                        left_q  <= left_d;
                        state_q <= SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (baud_tick) begin
                        txd_q   <= frame_q[0];
                        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                        state_q <= SH_SEND;
                    end
                end
                SH_SEND: begin
                    if (baud_tick) begin
                        if (left_q == '0) begin
                            txd_q   <= 1'b1;
                            state_q <= SH_IDLE;
                        end else begin
                            txd_q   <= frame_q[0];
                            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                            left_q  <= left_q - CNT_W'(1);
                        end
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign idle = (state_q == SH_IDLE);
    assign txd  = txd_q;

    // R1: the line is at mark whenever no frame is under way
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_IDLE) |-> txd_q);

    // R2: the first tick after arming drives the start bit low
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_ARMED && baud_tick) |=> !txd_q);

    // R2: the line only moves on a tick
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(txd_q));

    // R8: the final slot of every frame is high
    p_stop_high_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_SEND && left_q == '0) |-> txd_q);

    // R10: a new byte is only loaded between frames
    p_load_idle_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> (state_q == SH_IDLE));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = TX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MODE_W-1:0] in_mode,
    output logic              txd,
    output logic              empty_irq
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic [MODE_W-1:0] hold_mode;
    logic              sh_idle;
    logic              handoff;
    logic              irq_q;

    assign handoff = hold_full & sh_idle;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mode   (in_mode),
        .take      (handoff),
        .in_ready  (in_ready),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_mode (hold_mode)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .load      (handoff),
        .load_data (hold_data),
        .load_mode (hold_mode),
        .idle      (sh_idle),
        .txd       (txd)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= handoff;
    end

    assign empty_irq = irq_q;

    // R9: the interrupt is a single-cycle pulse
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        empty_irq |=> !empty_irq);

    // R9: when the interrupt fires the holding register is free
    p_irq_ready_r9: assert property (@(posedge clk) disable iff (rst)
        empty_irq |-> in_ready);

endmodule

// File: tb/uart_tx_core_bench.sv
module uart_tx_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BIT_CYC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [2:0] in_mode = 3'd0;
    logic       in_ready;
    logic       txd;
    logic       empty_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int fall_cnt = 0;
    int fall_cyc = 0;
    int tick_cnt = 0;
    logic txd_prev = 1'b1;
    bit finished = 1'b0;

    uart_tx_core u_uart_tx_core (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_mode   (in_mode),
        .txd       (txd),
        .empty_irq (empty_irq)
    );

    always #2 clk = ~clk;

    // baud strobe: one cycle high every BIT_CYC cycles
    always @(negedge clk) begin
        tick_cnt  = (tick_cnt == BIT_CYC - 1) ? 0 : tick_cnt + 1;
        baud_tick = (tick_cnt == BIT_CYC - 1);
    end

    // line monitor: counts cycles and records falling edges
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (txd_prev === 1'b1 && txd === 1'b0) begin
            fall_cnt = fall_cnt + 1;
            fall_cyc = cyc;
        end
        txd_prev = txd;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int build(input logic [7:0] d, input logic [2:0] m,
                                 output logic [10:0] b);
        logic ones;
        ones = ^d;
        b = '1;
        b[0] = 1'b0;
        b[8:1] = d;
        case (m)
            3'd1: begin b[9] = ~ones; return 11; end
            3'd2: begin b[9] = ones;  return 11; end
            3'd3: begin b[9] = 1'b0;  return 11; end
            3'd4: begin b[9] = 1'b1;  return 11; end
            default: return 10;
        endcase
    endfunction

    task automatic push(input logic [7:0] d, input logic [2:0] m);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_mode  = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // waits for the first fall after snap, then samples each slot mid-bit
    task automatic grab(input int snap, input logic [7:0] d, input logic [2:0] m,
                        input string ptag, output int start);
        logic [10:0] exp_b;
        int n;
        int guard;
        string tag;
        n = build(d, m, exp_b);
        guard = 0;
        start = 0;
        while (fall_cnt <= snap && guard < 40 * BIT_CYC) begin
            @(negedge clk);
            guard++;
        end
        if (fall_cnt <= snap) begin
            check(1'b0, "R2", "start bit never seen", 1, 0);
            return;
        end
        start = fall_cyc;
        for (int i = 0; i <= n; i++) begin
            while (cyc < start + BIT_CYC / 2 + i * BIT_CYC) @(negedge clk);
            if (i == 0)      tag = "R2";
            else if (i <= 8) tag = "R3";
            else if (i == 9 && n == 11)
                tag = (ptag != "") ? ptag : (m == 3'd1) ? "R4" : (m == 3'd2) ? "R5" : "R6";
            else if (n == 10) tag = "R7";
            else             tag = "R8";
            if (i < n)
                check(txd === exp_b[i], tag, $sformatf("byte %02h mode %0d slot %0d", d, m, i),
                      int'(txd), int'(exp_b[i]));
            else if (ptag == "")
                check(txd === 1'b1, "R8", $sformatf("idle after byte %02h", d), int'(txd), 1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(empty_irq === 1'b0, "R1", "irq after reset", int'(empty_irq), 0);
        repeat (3 * BIT_CYC) @(negedge clk);
        check(txd === 1'b1, "R1", "txd idle with nothing queued", int'(txd), 1);
    endtask

    task automatic t_handoff();
        int snap;
        int st;
        snap = fall_cnt;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = 8'h41; in_mode = 3'd1;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready === 1'b0, "R10", "ready while held", int'(in_ready), 0);
        check(empty_irq === 1'b0, "R9", "irq before handoff", int'(empty_irq), 0);
        @(negedge clk);
        check(empty_irq === 1'b1, "R9", "irq after handoff", int'(empty_irq), 1);
        check(in_ready === 1'b1, "R9", "ready with irq", int'(in_ready), 1);
        @(negedge clk);
        check(empty_irq === 1'b0, "R9", "irq pulse width", int'(empty_irq), 0);
        grab(snap, 8'h41, 3'd1, "", st);
    endtask

    task automatic t_parity();
        logic [7:0] ds [8] = '{8'h41, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h3C, 8'h00, 8'hFF};
        logic [2:0] ms [8] = '{3'd2, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd3};
        for (int k = 0; k < 8; k++) begin
            int snap;
            int st;
            snap = fall_cnt;
            push(ds[k], ms[k]);
            grab(snap, ds[k], ms[k], "", st);
        end
    endtask

    task automatic t_no_parity();
        logic [7:0] ds [3] = '{8'h80, 8'h5A, 8'h01};
        logic [2:0] ms [3] = '{3'd0, 3'd5, 3'd7};
        for (int k = 0; k < 3; k++) begin
            int snap;
            int st;
            snap = fall_cnt;
            push(ds[k], ms[k]);
            grab(snap, ds[k], ms[k], "", st);
        end
    endtask

    task automatic t_back_to_back();
        logic [2:0] ms [2] = '{3'd0, 3'd1};
        int fbits [2] = '{10, 11};
        for (int k = 0; k < 2; k++) begin
            int snap;
            int sa;
            int sb;
            snap = fall_cnt;
            push(8'h96, ms[k]);
            push(8'h69, ms[k]);
            check(in_ready === 1'b0, "R10", "ready while second byte waits", int'(in_ready), 0);
            grab(snap, 8'h96, ms[k], "R10", sa);
            snap = fall_cnt;
            grab(snap, 8'h69, ms[k], "", sb);
            check(sb - sa == (fbits[k] + 1) * BIT_CYC, (k == 0) ? "R7" : "R10",
                  "start-to-start spacing", sb - sa, (fbits[k] + 1) * BIT_CYC);
        end
    endtask

    task automatic t_mode_latch();
        int snap;
        int st;
        snap = fall_cnt;
        push(8'h07, 3'd1);
        in_mode = 3'd2;
        grab(snap, 8'h07, 3'd1, "R11", st);
        snap = fall_cnt;
        push(8'h55, 3'd4);
        push(8'h2C, 3'd3);
        in_mode = 3'd1;
        grab(snap, 8'h55, 3'd4, "R11", st);
        snap = fall_cnt;
        grab(snap, 8'h2C, 3'd3, "R11", st);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_handoff();
        t_parity();
        t_no_parity();
        t_back_to_back();
        t_mode_latch();
        repeat (2 * BIT_CYC) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule